// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel left and right samples for a DAC datapath. Both channels share one data line. A word-select line marks which channel each bit belongs to. The receiver runs on the bit clock and samples data and word-select on its rising edge.

Three framings are supported:

- **I2S:** the word arrives one bit after the word-select change, MSB first.
- **MSB-justified:** the word starts on the very bit where word-select changes.
- **LSB-justified:** the word ends on the last bit before word-select changes.

In LSB-justified mode the word length is 16, 18 or 20 bits. A static-pin control flag allows only 16 and 20. Every captured word is presented as a 20-bit value, left-aligned and zero-padded. A one-cycle pulse marks each completed stereo frame, and both channel outputs change together on that pulse.

A three-state machine tracks framing:

- **SYNC** is entered at reset. It moves to LEFT on the first half-frame boundary into the left channel. Any other boundary leaves it in SYNC.
- **LEFT** moves to RIGHT at the next boundary and stores the finished left word.
- **RIGHT** moves back to LEFT at the next boundary. On that transition it publishes the stored left word together with the finished right word and raises the frame pulse.

Top module: `audio_serial_rx`

## Requirements
- R1: Reset (rst_n low) is asynchronous. While it is low and after it is released, left_o and right_o are 0, frame_valid_o is 0, len_err_o is 0 and the machine is in SYNC.
- R2: When fmt_i is 0 (I2S), word-select low marks the left channel. The MSB of a word is the bit sampled one rising edge after word-select changes. Up to 20 bits are taken MSB first, and any further bits of the half-frame are ignored.
- R3: When fmt_i is 1 (MSB-justified), word-select high marks the left channel. The MSB is the first bit sampled with the new word-select level, and up to 20 bits are taken.
- R4: When fmt_i[1] is 1 (LSB-justified, codes 2 and 3), word-select high marks the left channel. The bit sampled just before word-select changes is the LSB, and the word is the final N bits of the half-frame. wlen_i gives N: 0 selects 16, 1 selects 18, and 2 or 3 selects 20.
- R5: A word shorter than 20 bits appears in the upper bits of the 20-bit output, with the unused low bits equal to zero.
- R6: frame_valid_o is high for exactly one cycle, in the cycle after the edge that samples the first bit of a new left half-frame that follows a captured right half-frame. left_o and right_o change only at that edge, and both change together.
- R7: In LSB-justified mode with pin_mode_i high, wlen_i code 1 is treated as a 20-bit word.
- R8: len_err_o becomes 1 after any rising edge at which fmt_i[1], pin_mode_i and wlen_i==1 are all true. It then stays at 1 until reset. No other combination sets it.
- R9: After reset, no frame pulse occurs until a complete left half-frame and a complete right half-frame have been received, both beginning at observed boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ws_i | input | 1 | Word-select (channel framing) |
| sdata_i | input | 1 | Serial audio data |
| fmt_i | input | 2 | Framing: 0 I2S, 1 MSB-justified, 2/3 LSB-justified |
| wlen_i | input | 2 | LSB-justified length: 0=16, 1=18, 2/3=20 |
| pin_mode_i | input | 1 | Static-pin control active; restricts LSB lengths |
| left_o | output | 20 | Left sample, left-aligned, zero-padded |
| right_o | output | 20 | Right sample, left-aligned, zero-padded |
| frame_valid_o | output | 1 | One-cycle pulse per completed stereo frame |
| len_err_o | output | 1 | Sticky flag for an illegal 18-bit request in pin mode |

## Verification
The hardest case to reach is a half-frame boundary whose position differs by one bit between framings. Under I2S the boundary is taken from the delayed word-select, so a format change mid-stream shifts every boundary. The bench changes format, length and control mode on a live stream and sends each test frame twice before checking. This makes sure the published frame lies wholly inside the new configuration. An 18-bit word in pin mode is sent inside a 32-bit slot, so the two zero bits ahead of it are visible and show that a 20-bit window was used.

// File: rtl/asr_pkg.sv
package asr_pkg;

    typedef enum logic [1:0] {
        ST_SYNC  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } rx_state_t;

    localparam logic [1:0] FMT_I2S  = 2'd0;
    localparam logic [1:0] FMT_MSBJ = 2'd1;

    localparam logic [1:0] WLEN_SHORT = 2'd0;
    localparam logic [1:0] WLEN_MID   = 2'd1;

endpackage

// File: rtl/asr_chan_track.sv
module asr_chan_track (
    input  logic bclk,
    input  logic rst_n,
    input  logic ws_i,
    input  logic is_i2s_i,
    output logic lft_o,
    output logic bnd_o
);
    logic ws_q;
    logic lft_q;

    // In I2S the channel of a bit follows the word-select of the previous edge.
    always_comb begin
        if (is_i2s_i) lft_o = ~ws_q;
        else          lft_o = ws_i;
    end

    assign bnd_o = lft_o ^ lft_q;

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            ws_q  <= 1'b0;
            lft_q <= 1'b0;
        end else begin
            ws_q  <= ws_i;
            lft_q <= lft_o;
        end
    end
endmodule

// File: rtl/asr_len_ctrl.sv
module asr_len_ctrl #(
    parameter int SAMPLE_W  = 20,
    parameter int LEN_SHORT = 16,
    parameter int LEN_MID   = 18,
    parameter int LEN_W     = $clog2(SAMPLE_W + 1)
) (
    input  logic             bclk,
    input  logic             rst_n,
    input  logic             is_lsb_i,
    input  logic [1:0]       wlen_i,
    input  logic             pin_mode_i,
    output logic [LEN_W-1:0] eff_len_o,
    output logic             len_err_o
);
    import asr_pkg::*;

    logic bad_req;

    always_comb begin
        unique case (wlen_i)
            WLEN_SHORT: eff_len_o = LEN_W'(LEN_SHORT);
            WLEN_MID:   eff_len_o = pin_mode_i ? LEN_W'(SAMPLE_W) : LEN_W'(LEN_MID);
            default:    eff_len_o = LEN_W'(SAMPLE_W);
        endcase
    end

    assign bad_req = is_lsb_i & pin_mode_i & (wlen_i == WLEN_MID);

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) len_err_o <= 1'b0;
        else        len_err_o <= len_err_o | bad_req;
    end

    assert_err_sticky_R8: assert property (@(posedge bclk) disable iff (!rst_n)
        len_err_o |=> len_err_o);

    assert_err_cause_R8: assert property (@(posedge bclk) disable iff (!rst_n)
        $rose(len_err_o) |-> $past(bad_req));
endmodule

// File: rtl/asr_capture.sv
module asr_capture #(
    parameter int SAMPLE_W = 20,
    parameter int LEN_W    = $clog2(SAMPLE_W + 1)
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                sdata_i,
    input  logic                bnd_i,
    input  logic                is_lsb_i,
    input  logic [LEN_W-1:0]    eff_len_i,
    output logic [SAMPLE_W-1:0] word_o
);
    localparam int CNT_W = $clog2(SAMPLE_W + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(SAMPLE_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SAMPLE_W - 1);

    logic [SAMPLE_W-1:0] msb_acc;
    logic [SAMPLE_W-1:0] lsb_sh;
    logic [CNT_W-1:0]    cnt;
    logic [CNT_W-1:0]    wr_idx;
    logic [LEN_W-1:0]    pad;
    logic [SAMPLE_W-1:0] keep_mask;
    logic [SAMPLE_W-1:0] lsb_aligned;

    assign wr_idx = LAST_IDX - cnt;

    // MSB-first fill counts bits; LSB window shifts continuously.
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            msb_acc <= '0;
            lsb_sh  <= '0;
            cnt     <= '0;
        end else if (bnd_i) begin
            msb_acc <= {sdata_i, {(SAMPLE_W-1){1'b0}}};
            lsb_sh  <= {{(SAMPLE_W-1){1'b0}}, sdata_i};
            cnt     <= CNT_W'(1);
        end else begin
            lsb_sh <= {lsb_sh[SAMPLE_W-2:0], sdata_i};
            if (cnt < CNT_MAX) begin
                msb_acc[wr_idx] <= sdata_i;
                cnt             <= cnt + CNT_W'(1);
            end
        end
    end

    always_comb begin
        pad         = LEN_W'(SAMPLE_W) - eff_len_i;
        keep_mask   = {SAMPLE_W{1'b1}} >> pad;
        lsb_aligned = (lsb_sh & keep_mask) << pad;
        word_o      = is_lsb_i ? lsb_aligned : msb_acc;
    end

    assert_cnt_bound_R2: assert property (@(posedge bclk) disable iff (!rst_n)
        (cnt == CNT_MAX && !bnd_i) |=> $stable(msb_acc));
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx #(
    parameter int SAMPLE_W  = 20,
    parameter int LEN_SHORT = 16,
    parameter int LEN_MID   = 18
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                ws_i,
    input  logic                sdata_i,
    input  logic [1:0]          fmt_i,
    input  logic [1:0]          wlen_i,
    input  logic                pin_mode_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                frame_valid_o,
    output logic                len_err_o
);
    import asr_pkg::*;

    localparam int LEN_W = $clog2(SAMPLE_W + 1);

    logic                is_i2s;
    logic                is_lsb;
    logic                lft;
    logic                bnd;
    logic [LEN_W-1:0]    eff_len;
    logic [SAMPLE_W-1:0] word;
    logic [SAMPLE_W-1:0] left_hold;
    rx_state_t           state_q;
    rx_state_t           state_d;

    assign is_i2s = (fmt_i == FMT_I2S);
    assign is_lsb = fmt_i[1];

    asr_chan_track u_track (
        .bclk     (bclk),
        .rst_n    (rst_n),
        .ws_i     (ws_i),
        .is_i2s_i (is_i2s),
        .lft_o    (lft),
        .bnd_o    (bnd)
    );

    asr_len_ctrl #(
        .SAMPLE_W  (SAMPLE_W),
        .LEN_SHORT (LEN_SHORT),
        .LEN_MID   (LEN_MID),
        .LEN_W     (LEN_W)
    ) u_len (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .is_lsb_i   (is_lsb),
        .wlen_i     (wlen_i),
        .pin_mode_i (pin_mode_i),
        .eff_len_o  (eff_len),
        .len_err_o  (len_err_o)
    );

    asr_capture #(
        .SAMPLE_W (SAMPLE_W),
        .LEN_W    (LEN_W)
    ) u_cap (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .sdata_i   (sdata_i),
        .bnd_i     (bnd),
        .is_lsb_i  (is_lsb),
        .eff_len_i (eff_len),
        .word_o    (word)
    );

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SYNC;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SYNC:  if (bnd && lft) state_d = ST_LEFT;
            ST_LEFT:  if (bnd)        state_d = ST_RIGHT;
            ST_RIGHT: if (bnd)        state_d = ST_LEFT;
            default:                  state_d = ST_SYNC;
        endcase
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            left_hold     <= '0;
            left_o        <= '0;
            right_o       <= '0;
            frame_valid_o <= 1'b0;
        end else begin
            frame_valid_o <= 1'b0;
            unique case (state_q)
                ST_LEFT: if (bnd) left_hold <= word;
                ST_RIGHT: if (bnd) begin
                    left_o        <= left_hold;
                    right_o       <= word;
                    frame_valid_o <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assert_pulse_single_R6: assert property (@(posedge bclk) disable iff (!rst_n)
        frame_valid_o |=> !frame_valid_o);

    assert_pulse_in_left_R6: assert property (@(posedge bclk) disable iff (!rst_n)
        frame_valid_o |-> (state_q == ST_LEFT));

    assert_outputs_hold_R6: assert property (@(posedge bclk) disable iff (!rst_n)
        !frame_valid_o |-> ($stable(left_o) && $stable(right_o)));

    assert_no_pulse_in_sync_R9: assert property (@(posedge bclk) disable iff (!rst_n)
        (state_q == ST_SYNC) |=> !frame_valid_o);
endmodule

// File: tb/audio_serial_rx_tb.sv
module audio_serial_rx_tb;
    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ws_i = 1'b0;
    logic        sdata_i = 1'b0;
    logic [1:0]  fmt_i = 2'd0;
    logic [1:0]  wlen_i = 2'd2;
    logic        pin_mode_i = 1'b0;
    logic [19:0] left_o;
    logic [19:0] right_o;
    logic        frame_valid_o;
    logic        len_err_o;

    int checks = 0;
    int errors = 0;
    int pulses = 0;

    // reference model state
    int          m_prev_ws;
    int          m_ch_prev;
    int          m_state;
    bit          m_bits[$];
    logic [19:0] m_lhold;
    logic [19:0] exp_l;
    logic [19:0] exp_r;
    bit          exp_v;
    bit          exp_e;

    always #5 bclk = ~bclk;

    audio_serial_rx u_dut (
        .bclk          (bclk),
        .rst_n         (rst_n),
        .ws_i          (ws_i),
        .sdata_i       (sdata_i),
        .fmt_i         (fmt_i),
        .wlen_i        (wlen_i),
        .pin_mode_i    (pin_mode_i),
        .left_o        (left_o),
        .right_o       (right_o),
        .frame_valid_o (frame_valid_o),
        .len_err_o     (len_err_o)
    );

    function automatic logic [19:0] model_word();
        logic [19:0] v = '0;
        int n = m_bits.size();
        if (fmt_i >= 2) begin
            int len = (wlen_i == 0) ? 16 : (wlen_i == 1) ? (pin_mode_i ? 20 : 18) : 20;
            int first = (n > len) ? n - len : 0;
            for (int i = first; i < n; i++) v = {v[18:0], m_bits[i]};
            return v << (20 - len);
        end
        for (int i = 0; i < n && i < 20; i++) v[19-i] = m_bits[i];
        return v;
    endfunction

    task automatic model_reset();
        m_prev_ws = 0; m_ch_prev = 0; m_state = 0;
        m_bits.delete();
        m_lhold = '0; exp_l = '0; exp_r = '0; exp_v = 0; exp_e = 0;
    endtask

    // Predicts outputs after the rising edge that samples (w, d).
    task automatic model_step(input logic w, input logic d);
        int ch = (fmt_i == 0) ? (m_prev_ws == 0) : (w == 1'b1);
        m_prev_ws = w;
        exp_v = 0;
        if (fmt_i >= 2 && pin_mode_i && wlen_i == 1) exp_e = 1;
        if (ch != m_ch_prev) begin
            logic [19:0] wd = model_word();
            if (m_state == 0) begin
                if (ch == 1) m_state = 1;
            end else if (m_state == 1) begin
                m_lhold = wd; m_state = 2;
            end else begin
                exp_l = m_lhold; exp_r = wd; exp_v = 1; m_state = 1;
            end
            m_bits.delete();
        end
        m_bits.push_back(d);
        m_ch_prev = ch;
    endtask

    task automatic compare();
        checks++;
        if (frame_valid_o) pulses++;
        if (left_o !== exp_l || right_o !== exp_r || frame_valid_o !== exp_v || len_err_o !== exp_e) begin
            errors++;
            $display("FAIL R2-R8 per-cycle model: l=%h r=%h v=%b e=%b expected l=%h r=%h v=%b e=%b",
                     left_o, right_o, frame_valid_o, len_err_o, exp_l, exp_r, exp_v, exp_e);
        end
    endtask

    task automatic check(input string req, input logic [19:0] act, input logic [19:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic send(input logic w, input logic d);
        @(negedge bclk);
        compare();
        ws_i = w; sdata_i = d;
        model_step(w, d);
    endtask

    task automatic hold_tick();
        @(negedge bclk);
        compare();
        model_step(ws_i, sdata_i);
    endtask

    task automatic set_cfg(input logic [1:0] f, input logic [1:0] wl, input logic pm);
        @(negedge bclk);
        compare();
        fmt_i = f; wlen_i = wl; pin_mode_i = pm;
        model_step(ws_i, sdata_i);
    endtask

    task automatic do_reset();
        @(negedge bclk);
        rst_n = 1'b0;
        repeat (3) @(posedge bclk);
        @(negedge bclk);
        rst_n = 1'b1;
        ws_i = 1'b0; sdata_i = 1'b0;
        model_reset();
        pulses = 0;
        check("R1 left", left_o, 20'h0);
        check("R1 right", right_o, 20'h0);
        check("R1 valid", {19'h0, frame_valid_o}, 20'h0);
        check("R1 err", {19'h0, len_err_o}, 20'h0);
        model_step(ws_i, sdata_i);
    endtask

    task automatic frame(input int slot, input int len, input logic [31:0] lv, input logic [31:0] rv);
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < slot; i++) begin
                logic [31:0] wv = (c == 0) ? lv : rv;
                logic b;
                logic w;
                int pos;
                if (fmt_i >= 2) begin
                    pos = i - (slot - len);
                    b = (pos >= 0) ? wv[len-1-pos] : 1'b0;
                end else begin
                    b = (i < len) ? wv[len-1-i] : 1'b0;
                end
                if (fmt_i == 0) begin
                    if (i < slot - 1) w = (c == 1);
                    else              w = (c == 0);
                end else begin
                    w = (c == 0);
                end
                send(w, b);
            end
        end
    endtask

    // Two identical frames, then the first left bit of the next frame.
    task automatic run_pair(input int slot, input int len, input logic [31:0] lv, input logic [31:0] rv);
        frame(slot, len, lv, rv);
        frame(slot, len, lv, rv);
        send((fmt_i == 0) ? 1'b0 : 1'b1, 1'b0);
        hold_tick();
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();

        // R2: I2S, 20-bit words in 32-bit slots
        set_cfg(2'd0, 2'd2, 1'b0);
        run_pair(32, 20, 32'h9A5C3, 32'h16E7B);
        check("R2 I2S left", left_o, 20'h9A5C3);
        check("R2 I2S right", right_o, 20'h16E7B);
        // R2: 24-bit words, extra bits ignored
        run_pair(32, 24, 32'hC3A5F1, 32'h5B7E29);
        check("R2 I2S long left", left_o, 20'hC3A5F);
        check("R2 I2S long right", right_o, 20'h5B7E2);
        // R5: 16-bit words in 16-bit slots
        run_pair(16, 16, 32'hABCD, 32'h1357);
        check("R5 I2S short left", left_o, 20'hABCD0);
        check("R5 I2S short right", right_o, 20'h13570);

        // R3: MSB-justified
        set_cfg(2'd1, 2'd2, 1'b0);
        run_pair(32, 20, 32'h3C6A9, 32'hF0E1D);
        check("R3 msbj left", left_o, 20'h3C6A9);
        check("R3 msbj right", right_o, 20'hF0E1D);
        run_pair(24, 18, 32'h2D4F1, 32'h10A3B);
        check("R5 msbj 18 left", left_o, 20'hB53C4);
        check("R5 msbj 18 right", right_o, 20'h428EC);

        // R4: LSB-justified, each length, register control
        set_cfg(2'd2, 2'd0, 1'b0);
        run_pair(32, 16, 32'hBEEF, 32'h4A71);
        check("R4 lsbj16 left", left_o, 20'hBEEF0);
        check("R4 lsbj16 right", right_o, 20'h4A710);
        set_cfg(2'd2, 2'd1, 1'b0);
        run_pair(32, 18, 32'h3A5C7, 32'h0F1E2);
        check("R4 lsbj18 left", left_o, 20'hE971C);
        check("R4 lsbj18 right", right_o, 20'h3C788);
        check("R8 no err in register mode", {19'h0, len_err_o}, 20'h0);
        set_cfg(2'd3, 2'd3, 1'b0);
        run_pair(32, 20, 32'h8C3E5, 32'h71B2A);
        check("R4 lsbj20 left", left_o, 20'h8C3E5);
        check("R4 lsbj20 right", right_o, 20'h71B2A);

        // R7/R8: pin mode, legal lengths and non-LSB code 1
        set_cfg(2'd2, 2'd0, 1'b1);
        run_pair(32, 16, 32'h6E2D, 32'h9B14);
        check("R7 pin 16 left", left_o, 20'h6E2D0);
        set_cfg(2'd0, 2'd1, 1'b1);
        run_pair(32, 20, 32'h55AA3, 32'hAA55C);
        check("R8 pin I2S code1 no err", {19'h0, len_err_o}, 20'h0);

        // R7: 18-bit request in pin mode captures a 20-bit window
        set_cfg(2'd2, 2'd1, 1'b1);
        run_pair(32, 18, 32'h3FFFF, 32'h2A5B3);
        check("R7 pin 18 as 20 left", left_o, 20'h3FFFF);
        check("R7 pin 18 as 20 right", right_o, 20'h2A5B3);
        check("R8 err set", {19'h0, len_err_o}, 20'h1);
        set_cfg(2'd2, 2'd2, 1'b0);
        run_pair(32, 20, 32'h12345, 32'h6789A);
        check("R8 err sticky", {19'h0, len_err_o}, 20'h1);

        // R9: start mid right half, only complete frames pulse
        do_reset();
        set_cfg(2'd1, 2'd2, 1'b0);
        for (int i = 0; i < 10; i++) send(1'b0, 1'b1);
        frame(32, 20, 32'hA1B2C, 32'hD3E4F);
        frame(32, 20, 32'h0F0F0, 32'hF0F0F);
        send(1'b1, 1'b0);
        hold_tick();
        check("R9 pulse count", 20'(pulses), 20'd2);
        check("R6 last left", left_o, 20'h0F0F0);
        check("R6 last right", right_o, 20'hF0F0F);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule